// File: doc/BRIEF.md
# Overcurrent Fault Restart Controller

This block sequences the gate drive of an external power switch around an overcurrent fault. A fault seen while the gate is on turns the gate off, requests the gate pull-down and raises a fault status. The fault is then latched. The latch cannot be released until an external comparator reports that the fault timer capacitor has discharged. After that point, one of two restart policies applies, chosen by a static mode input. In automatic-retry mode the block waits a retry interval and then turns the gate back on. In latchoff mode the block stays off until something outside clears the latch: a qualified shutdown pulse, a qualified undervoltage-lockout pulse or a supply-window (UV/OV) fault. A clear of that kind leads through a debounce interval before the gate turns on again.

All time intervals are counted in pulses of a slow tick enable. The retry, qualification and debounce lengths are parameters given in ticks. Outside the fault path, the shutdown, lockout and UV/OV inputs also hold the gate off while they are present. The gate then returns only after a debounce interval.

Top module: `restart_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `gate_en` is 0, `gate_pd` is 1 and `fault_stat` is 0.
- R2: With no blocking input present, the gate-off state moves to debounce on the next clock. `gate_en` rises on the clock edge that sees the DEB_TICKS-th tick pulse in debounce, and never on a cycle without a tick. `gate_pd` is 0 during debounce.
- R3: Any blocking input (`shdn_n` low, `uvlo` high or `uvlo_ovp` high) present at a clock edge makes `gate_en` 0 after that edge. Without a latched fault, `gate_pd` is also 1.
- R4: `fault_det` high while `gate_en` is 1 gives `gate_en` 0, `gate_pd` 1 and `fault_stat` 1 after the next edge.
- R5: While the latched fault waits for `tmr_low`, no input clears it: shutdown, lockout and UV/OV leave `gate_en` 0, `gate_pd` 1 and `fault_stat` 1.
- R6: With `mode_auto`=1, once `tmr_low` has been seen the gate turns on directly, with no debounce, at the RETRY_TICKS-th tick after that.
- R7: With `mode_auto`=0, a latched fault never restarts by itself. Only a clear (R8, R9 or R10) followed by debounce turns the gate back on.
- R8: Once the timer has discharged, `shdn_n` held low for QUAL_TICKS consecutive tick pulses clears the latch on the following edge. A high level before that restarts the count from zero.
- R9: `uvlo` held high for QUAL_TICKS consecutive tick pulses clears the latch in the same way, with the same restart on dropout.
- R10: `uvlo_ovp` high clears a discharged latch at the next edge, with no qualification, in either mode.
- R11: After a clear, the block stays in gate-off (`gate_pd`=1) while any blocking input remains. It then debounces (R2) before `gate_en` rises.
- R12: `fault_stat` rises with fault entry. It falls on the same edge where `gate_en` next rises, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow time-base enable, one cycle wide per tick |
| fault_det | input | 1 | Overcurrent fault detected |
| tmr_low | input | 1 | Fault timer capacitor has discharged |
| shdn_n | input | 1 | Active-low shutdown request |
| uvlo | input | 1 | Supply below lockout level |
| uvlo_ovp | input | 1 | Supply outside the UV/OV window |
| mode_auto | input | 1 | Static policy select: 1 automatic retry, 0 latchoff |
| gate_en | output | 1 | Gate drive enabled |
| gate_pd | output | 1 | Gate pull-down request |
| fault_stat | output | 1 | Overcurrent fault status |

## Verification
Several rules are checked by the assertions on every cycle. A blocking input always leaves the gate off after the edge. A fault while the gate is on always sets the status. The status falls only together with a rising gate. The gate never rises without a tick. In latchoff mode the gate rises only out of debounce, and a qualification flag appears only after its input was held.

The exact lengths of debounce and retry and the restart of the qualification count after a dropout can only be shown by the bench's scenarios. The same holds for the refusal to clear before discharge and for the ordering of clear, blocking and debounce. The bench scenarios compare each output on every cycle against a reference model built from the requirements.

// File: rtl/restart_pkg.sv
package restart_pkg;

  typedef enum logic [2:0] {
    RS_OFF   = 3'd0,
    RS_DEB   = 3'd1,
    RS_ON    = 3'd2,
    RS_FAULT = 3'd3,
    RS_RETRY = 3'd4,
    RS_HOLD  = 3'd5
  } rs_state_e;

  // width needed to hold values 0..n
  function automatic int bits_for(input int n);
    int w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // states in which the pull-down is requested
  function automatic logic pulls_down(input rs_state_e s);
    return (s == RS_OFF) || (s == RS_FAULT) || (s == RS_RETRY) || (s == RS_HOLD);
  endfunction

  // states in which the interval timer advances
  function automatic logic times_interval(input rs_state_e s);
    return (s == RS_DEB) || (s == RS_RETRY);
  endfunction

  // states in which a discharged latch may be cleared
  function automatic logic may_clear(input rs_state_e s);
    return (s == RS_RETRY) || (s == RS_HOLD);
  endfunction

endpackage

// File: rtl/restart_qual.sv
// Counts consecutive tick pulses while a level is held; any dropout restarts.
module restart_qual #(
  parameter int QUAL_TICKS = 10,
  localparam int QW = restart_pkg::bits_for(QUAL_TICKS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic level,
  output logic qualified
);

  localparam logic [QW-1:0] QLIM = QW'(QUAL_TICKS);

  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!level)
      cnt_q <= '0;
    else if (tick && (cnt_q != QLIM))
      cnt_q <= cnt_q + 1'b1;
  end

  assign qualified = (cnt_q == QLIM);

endmodule

// File: rtl/restart_timer.sv
// Interval counter shared by debounce and retry.
module restart_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] last,
  output logic          expire
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (restart)
      cnt_q <= '0;
    else if (run && tick)
      cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && tick && (cnt_q == last);

endmodule

// File: rtl/restart_fsm.sv
module restart_fsm
  import restart_pkg::*;
#(
  parameter int CW = 8,
  parameter int DEB_TICKS = 4,
  parameter int RETRY_TICKS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault_det,
  input  logic          tmr_low,
  input  logic          blocked,
  input  logic          clr_req,
  input  logic          mode_auto,
  input  logic          tmr_expire,
  output logic          tmr_restart,
  output logic          tmr_run,
  output logic [CW-1:0] tmr_last,
  output rs_state_e     state,
  output logic          latch_clr,
  output logic          fault_stat
);

  localparam logic [CW-1:0] DEB_LAST = CW'(DEB_TICKS - 1);
  localparam logic [CW-1:0] RET_LAST = CW'(RETRY_TICKS - 1);

  rs_state_e st_q, st_d;
  logic      stat_q, stat_d;

  assign latch_clr = may_clear(st_q) && clr_req;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      RS_OFF:   if (!blocked) st_d = RS_DEB;
      RS_DEB: begin
        if (blocked)         st_d = RS_OFF;
        else if (tmr_expire) st_d = RS_ON;
      end
      RS_ON: begin
        if (fault_det)    st_d = RS_FAULT;
        else if (blocked) st_d = RS_OFF;
      end
      RS_FAULT: if (tmr_low) st_d = mode_auto ? RS_RETRY : RS_HOLD;
      RS_RETRY: begin
        if (latch_clr)       st_d = blocked ? RS_OFF : RS_DEB;
        else if (tmr_expire) st_d = blocked ? RS_OFF : RS_ON;
      end
      RS_HOLD:  if (latch_clr) st_d = blocked ? RS_OFF : RS_DEB;
      default:  st_d = RS_OFF;
    endcase
  end

  always_comb begin
    stat_d = stat_q;
    if (st_d == RS_FAULT && st_q == RS_ON) stat_d = 1'b1;
    else if (st_d == RS_ON)                stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_OFF;
      stat_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      stat_q <= stat_d;
    end
  end

  assign tmr_restart = (st_d != st_q);
  assign tmr_run     = times_interval(st_q);
  assign tmr_last    = (st_q == RS_RETRY) ? RET_LAST : DEB_LAST;
  assign state       = st_q;
  assign fault_stat  = stat_q;

endmodule

// File: rtl/restart_ctrl.sv
module restart_ctrl
  import restart_pkg::*;
#(
  parameter int QUAL_TICKS  = 10,
  parameter int DEB_TICKS   = 4000,
  parameter int RETRY_TICKS = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fault_det,
  input  logic tmr_low,
  input  logic shdn_n,
  input  logic uvlo,
  input  logic uvlo_ovp,
  input  logic mode_auto,
  output logic gate_en,
  output logic gate_pd,
  output logic fault_stat
);

  localparam int CW     = bits_for(max2(DEB_TICKS, RETRY_TICKS));
  localparam int NQUAL  = 2;

  logic [NQUAL-1:0] qual_lvl;
  logic [NQUAL-1:0] qual_hit;
  logic             blocked;
  logic             clr_req;
  logic             tmr_restart, tmr_run, tmr_expire;
  logic [CW-1:0]    tmr_last;
  rs_state_e        state;
  logic             latch_clr;
  logic             in_debounce;

  // index 0: shutdown held, index 1: lockout held
  assign qual_lvl = {uvlo, ~shdn_n};

  for (genvar g = 0; g < NQUAL; g++) begin : g_qual
    restart_qual #(.QUAL_TICKS(QUAL_TICKS)) i_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .level     (qual_lvl[g]),
      .qualified (qual_hit[g])
    );
  end

  assign blocked = ~shdn_n | uvlo | uvlo_ovp;
  assign clr_req = uvlo_ovp | (|qual_hit);

  restart_timer #(.CW(CW)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .run     (tmr_run),
    .tick    (tick),
    .last    (tmr_last),
    .expire  (tmr_expire)
  );

  restart_fsm #(
    .CW          (CW),
    .DEB_TICKS   (DEB_TICKS),
    .RETRY_TICKS (RETRY_TICKS)
  ) i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_det   (fault_det),
    .tmr_low     (tmr_low),
    .blocked     (blocked),
    .clr_req     (clr_req),
    .mode_auto   (mode_auto),
    .tmr_expire  (tmr_expire),
    .tmr_restart (tmr_restart),
    .tmr_run     (tmr_run),
    .tmr_last    (tmr_last),
    .state       (state),
    .latch_clr   (latch_clr),
    .fault_stat  (fault_stat)
  );

  assign in_debounce = (state == RS_DEB);
  assign gate_en     = (state == RS_ON);
  assign gate_pd     = pulls_down(state);

endmodule

// File: rtl/restart_ctrl_chk.sv
module restart_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       fault_det,
  input logic       shdn_n,
  input logic       uvlo,
  input logic       uvlo_ovp,
  input logic       mode_auto,
  input logic       gate_en,
  input logic       fault_stat,
  input logic       in_debounce,
  input logic [1:0] qual_hit
);

  // R3
  blocked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shdn_n || uvlo || uvlo_ovp) |=> !gate_en);

  // R4
  fault_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && fault_det) |=> (!gate_en && fault_stat));

  // R12
  stat_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_stat) |-> $rose(gate_en));

  // R2
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> $past(tick));

  // R7
  latchoff_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_auto && $rose(gate_en)) |-> $past(in_debounce));

  // R8
  shdn_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual_hit[0]) |-> $past(!shdn_n));

  // R9
  uvlo_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual_hit[1]) |-> $past(uvlo));

endmodule

bind restart_ctrl restart_ctrl_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .fault_det   (fault_det),
  .shdn_n      (shdn_n),
  .uvlo        (uvlo),
  .uvlo_ovp    (uvlo_ovp),
  .mode_auto   (mode_auto),
  .gate_en     (gate_en),
  .fault_stat  (fault_stat),
  .in_debounce (in_debounce),
  .qual_hit    (qual_hit)
);

// File: tb/test_restart_ctrl.sv
`timescale 1ns/1ps
module test_restart_ctrl;

  localparam int Q = 3;
  localparam int D = 5;
  localparam int R = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, fault_det = 1'b0, tmr_low = 1'b0, shdn_n = 1'b1;
  logic uvlo = 1'b0, uvlo_ovp = 1'b0, mode_auto = 1'b0;
  logic gate_en, gate_pd, fault_stat;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  restart_ctrl #(.QUAL_TICKS(Q), .DEB_TICKS(D), .RETRY_TICKS(R)) i_restart_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fault_det(fault_det), .tmr_low(tmr_low),
    .shdn_n(shdn_n), .uvlo(uvlo), .uvlo_ovp(uvlo_ovp), .mode_auto(mode_auto),
    .gate_en(gate_en), .gate_pd(gate_pd), .fault_stat(fault_stat)
  );

  // reference model: phases 0 idle-off, 1 settling, 2 driving, 3 tripped,
  // 4 auto wait, 5 parked
  int  m_ph = 0, m_cnt = 0, m_sq = 0, m_uq = 0;
  bit  m_stat = 0;

  function automatic bit exp_gate(input int ph);
    return ph == 2;
  endfunction

  function automatic bit exp_pd(input int ph);
    return !(ph == 1 || ph == 2);
  endfunction

  task automatic model_step();
    bit blk, clr, done;
    int nx;
    blk  = !shdn_n || uvlo || uvlo_ovp;
    clr  = uvlo_ovp || (m_sq == Q) || (m_uq == Q);
    done = tick && (m_cnt == ((m_ph == 4) ? R - 1 : D - 1));
    nx = m_ph;
    case (m_ph)
      0: nx = blk ? 0 : 1;
      1: nx = blk ? 0 : (done ? 2 : 1);
      2: nx = fault_det ? 3 : (blk ? 0 : 2);
      3: nx = tmr_low ? (mode_auto ? 4 : 5) : 3;
      4: nx = clr ? (blk ? 0 : 1) : (done ? (blk ? 0 : 2) : 4);
      5: nx = clr ? (blk ? 0 : 1) : 5;
      default: nx = 0;
    endcase
    if (m_ph == 2 && nx == 3) m_stat = 1;
    else if (nx == 2)         m_stat = 0;
    if (nx != m_ph) m_cnt = 0;
    else if ((m_ph == 1 || m_ph == 4) && tick) m_cnt++;
    if (shdn_n) m_sq = 0; else if (tick && m_sq < Q) m_sq++;
    if (!uvlo)  m_uq = 0; else if (tick && m_uq < Q) m_uq++;
    m_ph = nx;
  endtask

  task automatic chk(input bit got, input bit exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk(gate_en,    exp_gate(m_ph), "R11 gate_en vs model");
    chk(gate_pd,    exp_pd(m_ph),   "R3 gate_pd vs model");
    chk(fault_stat, m_stat,         "R12 fault_stat vs model");
  endtask

  task automatic step(input int n, input bit t);
    for (int i = 0; i < n; i++) begin
      tick = t;
      @(posedge clk);
      if (rst_n) model_step();
      @(negedge clk);
      cmp_model();
    end
    tick = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0c4231));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(gate_en, 1'b0, "R1 gate_en in reset");
    chk(gate_pd, 1'b1, "R1 gate_pd in reset");
    chk(fault_stat, 1'b0, "R1 fault_stat in reset");
    rst_n = 1'b1;
    step(1, 0);
    // R2 debounce with pull-down released
    step(1, 0);
    chk(gate_pd, 1'b0, "R2 pd low in debounce");
    step(D - 1, 1);
    chk(gate_en, 1'b0, "R2 not yet on");
    step(1, 1);
    chk(gate_en, 1'b1, "R2 on after debounce");
    // R4 trip
    fault_det = 1'b1; step(1, 0); fault_det = 1'b0;
    chk(gate_en, 1'b0, "R4 gate off");
    chk(fault_stat, 1'b1, "R4 status set");
    chk(gate_pd, 1'b1, "R4 pull-down");
    // R5 no clear before discharge
    shdn_n = 1'b0; uvlo_ovp = 1'b1; step(Q + 2, 1);
    shdn_n = 1'b1; uvlo_ovp = 1'b0; step(3, 1);
    chk(fault_stat, 1'b1, "R5 latch kept");
    chk(gate_en, 1'b0, "R5 gate kept off");
    // R7 latchoff never restarts alone
    tmr_low = 1'b1; step(1, 0);
    step(R + D + 4, 1);
    chk(gate_en, 1'b0, "R7 no self restart");
    chk(gate_pd, 1'b1, "R7 pull-down held");
    // R8 dropout restarts qualification
    shdn_n = 1'b0; step(Q - 1, 1); shdn_n = 1'b1; step(1, 0);
    shdn_n = 1'b0; step(Q - 1, 1); shdn_n = 1'b1; step(1, 0);
    chk(fault_stat, 1'b1, "R8 short pulses do not clear");
    shdn_n = 1'b0; step(Q, 1); step(1, 0);
    // R11 cleared but still blocked
    chk(gate_pd, 1'b1, "R11 off while shutdown held");
    shdn_n = 1'b1; step(1, 0);
    chk(gate_pd, 1'b0, "R8 cleared into debounce");
    step(D, 1);
    chk(gate_en, 1'b1, "R11 on after debounce");
    chk(fault_stat, 1'b0, "R12 status falls with gate");
    // R9 lockout clear
    fault_det = 1'b1; step(1, 0); fault_det = 1'b0; step(1, 0);
    uvlo = 1'b1; step(Q, 1); step(1, 0);
    chk(fault_stat, 1'b1, "R12 status held through clear");
    uvlo = 1'b0; step(1, 0); step(D, 1);
    chk(gate_en, 1'b1, "R9 lockout clear restarts");
    // R10 UV/OV clear without qualification
    fault_det = 1'b1; step(1, 0); fault_det = 1'b0; step(1, 0);
    uvlo_ovp = 1'b1; step(2, 0);
    chk(gate_pd, 1'b1, "R10 held off during UV/OV");
    uvlo_ovp = 1'b0; step(1, 0);
    chk(gate_pd, 1'b0, "R10 cleared into debounce");
    step(D, 1);
    chk(gate_en, 1'b1, "R10 on after debounce");
    // R6 automatic retry
    mode_auto = 1'b1; tmr_low = 1'b0;
    fault_det = 1'b1; step(1, 0); fault_det = 1'b0; step(2, 1);
    tmr_low = 1'b1; step(1, 0);
    step(R - 1, 1);
    chk(gate_en, 1'b0, "R6 before retry elapses");
    step(1, 1);
    chk(gate_en, 1'b1, "R6 on after retry");
    chk(fault_stat, 1'b0, "R12 cleared on retry");
    // R3 blocking
    shdn_n = 1'b0; step(1, 0);
    chk(gate_en, 1'b0, "R3 shutdown turns off");
    chk(gate_pd, 1'b1, "R3 shutdown pulls down");
    shdn_n = 1'b1; step(1, 0);
    // constrained random, both policies
    for (int blkn = 0; blkn < 4; blkn++) begin
      mode_auto = blkn[0];
      for (int c = 0; c < 1500; c++) begin
        fault_det = ($urandom_range(0, 29) == 0);
        if ($urandom_range(0, 14) == 0) tmr_low  = ~tmr_low;
        if ($urandom_range(0, 24) == 0) shdn_n   = ~shdn_n;
        if ($urandom_range(0, 39) == 0) uvlo     = ~uvlo;
        if ($urandom_range(0, 59) == 0) uvlo_ovp = ~uvlo_ovp;
        if (uvlo_ovp && $urandom_range(0, 3) == 0) uvlo_ovp = 1'b0;
        step(1, $urandom_range(0, 2) == 0);
      end
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule